// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration frames from a three-wire serial port (a serial clock, a serial data line and a latch strobe) and turns each frame into a parallel update of one of seven configuration registers. All three serial lines are asynchronous to the system clock. They are resynchronised into the system clock domain, and their rising edges are detected there. Each detected rising edge of the serial clock shifts one data bit into a 24-bit shift register. The first bit sent lands in the most significant position.

When the latch strobe rises, the three least significant bits of the shift register name the destination. These are the last three bits shifted in. Values 0 to 6 select one of the seven registers, and the whole 24-bit frame is copied into that register. Value 7 selects nothing. In the same cycle that a register takes its new value, a one-hot update strobe marks which register changed. Downstream logic can use that strobe to act on the new setting, for example to retune a divider in response to a single frame.

Top module: `cfgSerialLoader`

## Requirements
- R1: Each rising edge of the serial clock shifts the serial data bit into bit 0 of the 24-bit shift register, and the older bits move one place up. The first bit of a frame therefore ends in bit 23.
- R2: Any number of bits may be shifted while the latch strobe is low. Only the last 24 bits shifted before the latch strobe's rising edge form the frame.
- R3: On a latch-strobe rising edge, frame bits [2:0] give a destination index. An index from 0 to 6 writes the full 24-bit frame into register `regsOut[index*24 +: 24]`.
- R4: A destination index of 7 is ignored. No register changes and no update strobe is raised.
- R5: `updStrobe[index]` is high for exactly one system-clock cycle per accepted frame. That is the same cycle in which the new contents first appear on `regsOut`, and no other strobe bit is high at that time.
- R6: While `rstN` is low, all registers and all strobe bits are zero.
- R7: Registers that are not addressed keep their value across any frame.
- R8: If a serial-clock rising edge and a latch-strobe rising edge are detected in the same system cycle, the load uses the frame shifted before that edge. The coincident data bit becomes the first bit of the next frame.
- R9: A latch strobe held high for many cycles causes exactly one load. A serial clock held high shifts exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, most significant bit first |
| serLatch | input | 1 | Latch strobe; its rising edge loads the frame |
| regsOut | output | 168 | Seven 24-bit registers; register k is at bits [k*24+23:k*24] |
| updStrobe | output | 7 | One-hot, one-cycle update flag per register |

## Verification
The two functions that can fall into one system cycle are a shift and a load. Both edges pass through synchronisers of equal depth. The bench therefore provokes the collision by raising the serial clock and the latch strobe on the same cycle, with a fresh data bit already in place. It then judges the result against its own bit model. The addressed register must hold the frame from before that bit. A following frame, which starts with that bit and is completed by 23 more, must land intact in its own register.

// File: rtl/cfgLoaderPkg.sv
package cfgLoaderPkg;
  // Per-cycle commands from the synchroniser/control to the datapath
  typedef struct packed {
    logic shiftEn;  // serial clock rising edge seen this cycle
    logic loadEn;   // latch strobe rising edge seen this cycle
    logic dataBit;  // data bit aligned with shiftEn
  } loaderCtrl_t;
endpackage

// File: rtl/loaderCtrl.sv
module loaderCtrl
  import cfgLoaderPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output loaderCtrl_t ctrl
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  // Extra stage on clock and latch lines keeps the previous synced value
  logic [PIPE_W-1:0]      clkPipe;
  logic [PIPE_W-1:0]      latchPipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe   <= '0;
      latchPipe <= '0;
      dataPipe  <= '0;
    end else begin
      clkPipe   <= {clkPipe[PIPE_W-2:0], serClk};
      latchPipe <= {latchPipe[PIPE_W-2:0], serLatch};
      dataPipe  <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  always_comb begin
    ctrl.shiftEn = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
    ctrl.loadEn  = latchPipe[SYNC_STAGES-1] & ~latchPipe[SYNC_STAGES];
    ctrl.dataBit = dataPipe[SYNC_STAGES-1];
  end
endmodule

// File: rtl/loaderDatapath.sv
module loaderDatapath
  import cfgLoaderPkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  loaderCtrl_t                  ctrl,
  output logic [NUM_REGS*FRAME_W-1:0]  regsOut,
  output logic [NUM_REGS-1:0]          updStrobe
);
  logic [FRAME_W-1:0]  shiftReg;
  logic [ADDR_W-1:0]   addrField;
  logic [NUM_REGS-1:0] hit;

  assign addrField = shiftReg[ADDR_W-1:0];

  // A coincident load sees the pre-shift value (nonblocking update)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctrl.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], ctrl.dataBit};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    assign hit[g] = ctrl.loadEn && (addrField == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regsOut[g*FRAME_W +: FRAME_W] <= '0;
      else if (hit[g]) regsOut[g*FRAME_W +: FRAME_W] <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updStrobe <= '0;
    else updStrobe <= hit;
  end
endmodule

// File: rtl/cfgSerialLoader.sv
module cfgSerialLoader
  import cfgLoaderPkg::*;
#(
  parameter int FRAME_W     = 24,
  parameter int ADDR_W      = 3,
  parameter int NUM_REGS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        serClk,
  input  logic                        serData,
  input  logic                        serLatch,
  output logic [NUM_REGS*FRAME_W-1:0] regsOut,
  output logic [NUM_REGS-1:0]         updStrobe
);
  loaderCtrl_t ctrl;

  loaderCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .ctrl(ctrl)
  );

  loaderDatapath #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .regsOut(regsOut), .updStrobe(updStrobe)
  );
endmodule

// File: rtl/cfgSerialLoaderChk.sv
module cfgSerialLoaderChk #(
  parameter int FRAME_W  = 24,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 7
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_REGS*FRAME_W-1:0] regsOut,
  input logic [NUM_REGS-1:0]         updStrobe
);
  // R6: reset clears everything
  always @(posedge clk) begin
    if (!rstN) begin
      a_r6_reset_clear: assert (regsOut == '0 && updStrobe == '0)
        else $error("R6 violated: state not clear in reset");
    end
  end

  // R5: at most one register flagged at a time
  a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updStrobe));

  // R5, R9: strobe lasts a single cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe != '0) |=> (updStrobe == '0));

  for (genvar g = 0; g < NUM_REGS; g++) begin : gChk
    // R7: a register only changes in its own strobe cycle
    a_r7_change_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
      (regsOut[g*FRAME_W +: FRAME_W] != $past(regsOut[g*FRAME_W +: FRAME_W])) |-> updStrobe[g]);
    // R3: the stored frame carries its own destination index
    a_r3_addr_match: assert property (@(posedge clk) disable iff (!rstN)
      updStrobe[g] |-> (regsOut[g*FRAME_W +: ADDR_W] == ADDR_W'(g)));
  end
endmodule

bind cfgSerialLoader cfgSerialLoaderChk #(
  .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) uChk (
  .clk(clk), .rstN(rstN), .regsOut(regsOut), .updStrobe(updStrobe)
);

// File: tb/tb_cfgSerialLoader.sv
module tb_cfgSerialLoader;
  localparam int FW = 24;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic [NR*FW-1:0] regsOut;
  logic [NR-1:0] updStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [FW-1:0] model = '0;
  logic [FW-1:0] expRegs [NR];

  always #4 clk = ~clk;

  cfgSerialLoader dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .regsOut(regsOut), .updStrobe(updStrobe)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    for (int r = 0; r < NR; r++)
      chk(regsOut[r*FW +: FW] == expRegs[r], req, $sformatf("reg%0d contents", r),
          32'(regsOut[r*FW +: FW]), 32'(expRegs[r]));
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    waitCyc(2);
    serClk = 1'b1;
    model = {model[FW-2:0], b};
    waitCyc(3);
    serClk = 1'b0;
    waitCyc(3);
  endtask

  task automatic shiftWord(input logic [FW-1:0] w);
    for (int i = FW - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  // Called with serLatch just raised; observes strobe and contents
  task automatic observeLoad(input logic [FW-1:0] word, input string req);
    int pulses = 0;
    logic [NR-1:0] seen = '0;
    int idx = int'(word[2:0]);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (updStrobe != '0) begin
        pulses++;
        seen = updStrobe;
        if (idx < NR)
          chk(regsOut[idx*FW +: FW] == word, "R5", "contents in strobe cycle",
              32'(regsOut[idx*FW +: FW]), 32'(word));
      end
    end
    if (idx < NR) begin
      chk(pulses == 1, "R9", "strobe pulse count", 32'(pulses), 32'd1);
      chk(seen == NR'(1 << idx), "R5", "strobe one-hot index", 32'(seen), 32'(1 << idx));
      expRegs[idx] = word;
    end else begin
      chk(pulses == 0, "R4", "strobe on ignored index", 32'(pulses), 32'd0);
    end
    checkRegs(req);
  endtask

  task automatic doLatch(input string req);
    logic [FW-1:0] word = model;
    serLatch = 1'b1;
    observeLoad(word, req);
    serLatch = 1'b0;
    waitCyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [FW-1:0] frameA;
    logic [FW-1:0] w;
    seedDummy = $urandom(32'h5EED_1234);
    for (int r = 0; r < NR; r++) expRegs[r] = '0;

    // R6: reset state
    waitCyc(3);
    chk(regsOut == '0, "R6", "regs in reset", 32'(regsOut[31:0]), 32'd0);
    chk(updStrobe == '0, "R6", "strobe in reset", 32'(updStrobe), 32'd0);
    rstN = 1'b1;
    waitCyc(4);
    checkRegs("R6");

    // R1: first bit sent lands in bit 23
    shiftWord(24'h800001);
    doLatch("R1");

    // R2: leading extra bits are discarded
    for (int i = 0; i < 5; i++) shiftBit(1'b1);
    shiftWord(24'h3C5A0B);
    doLatch("R2");

    // R4: index 7 changes nothing
    shiftWord(24'hFFFFFF);
    doLatch("R4");

    // R3 / R7: every valid index in turn
    for (int r = 0; r < NR; r++) begin
      shiftWord({21'($urandom), 3'(r)});
      doLatch("R3");
    end

    // R8: serial clock edge coincides with latch edge
    frameA = 24'h0F0F02;
    shiftWord(frameA);
    serData = 1'b1;
    waitCyc(2);
    serClk = 1'b1;
    serLatch = 1'b1;
    model = {model[FW-2:0], 1'b1};
    observeLoad(frameA, "R8");
    serClk = 1'b0;
    serLatch = 1'b0;
    waitCyc(4);
    w = {1'b1, 23'h12_3454};        // index 4, first bit already sent
    for (int i = FW - 2; i >= 0; i--) shiftBit(w[i]);
    chk(model == w, "R8", "bench model frame", 32'(model), 32'(w));
    doLatch("R8");

    // R9: long latch hold with shift-free gap loads once
    shiftWord(24'hABCDE5);
    serLatch = 1'b1;
    observeLoad(24'hABCDE5, "R9");
    waitCyc(30);
    chk(updStrobe == '0, "R9", "no reload while held", 32'(updStrobe), 32'd0);
    serLatch = 1'b0;
    waitCyc(4);

    // Random frames, with random leading junk
    for (int f = 0; f < 40; f++) begin
      int junk = int'($urandom_range(0, 4));
      for (int j = 0; j < junk; j++) shiftBit(1'($urandom));
      shiftWord(24'($urandom));
      doLatch("R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule